// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side character store of a memory-mapped serial port. Received characters arrive with four per-character error flags and are queued in a circular buffer described by a read position and an occupancy count. Software takes characters out by reading the data register, which shows up here as a pop strobe. The queue either runs as a multi-entry FIFO or collapses to a single holding register. The mode is picked by a FIFO-enable control, and any change of that control empties the queue.

The block keeps the full and empty flags and a can-accept signal for the deserialiser. It produces one-cycle pulses that set and clear the receive interrupt at the trigger level. It also holds a receive status register: each pop loads it with the error flags of the character that was popped, and a status-clear strobe zeroes it. A received break is stored as a marked entry. Bit timing and deserialisation sit outside this block.

Top module: `uart_rxq`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0, can_accept is 1, rx_status is 0, both interrupt pulses are 0, and the queue is in single-entry mode until fifo_en has been 1 for one clock edge.
- R2: With fifo_en at 1, the queue holds DEPTH (16) entries and returns them in arrival order. rx_full is 1 exactly when 16 entries are held and is never 1 together with rx_empty.
- R3: A push while the queue is full is dropped. The count never exceeds the effective depth, can_accept is 0 while the queue is full, and the stored order is unchanged.
- R4: With fifo_en at 0, the effective depth is 1: one push makes rx_full 1, and a second push is dropped.
- R5: A push that brings the count equal to the trigger level (1) gives rx_irq_set high for the one cycle after the clock edge that accepted it.
- R6: A pop that leaves the count one below the trigger level gives rx_irq_clr high for the one cycle after that edge. This includes a pop of an empty queue.
- R7: head_data[7:0] is the oldest character and head_data[11:8] are its flags: bit 8 framing, bit 9 parity, bit 10 break, bit 11 overrun. A pop loads those four flags, in the same order, into rx_status.
- R8: A stat_clr strobe with no pop in the same cycle makes rx_status 0. When both come in the same cycle, the pop's load wins.
- R9: A change of fifo_en empties the queue: rx_empty becomes 1 and rx_full becomes 0, and any push or pop in that cycle is ignored. The new mode applies from the next cycle.
- R10: A flush strobe empties the queue in the same way, and the next push is the new head.
- R11: An rx_break strobe pushes one entry with character 0x00 and only the break flag set (head_data = 0x400). It takes precedence over rx_valid in the same cycle.
- R12: A pop and a push in the same cycle remove the head and append the new character. If the count was 1, both rx_irq_clr and rx_irq_set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Push a received character |
| rx_data | input | 8 | Received character |
| rx_err | input | 4 | Flags: [0] framing, [1] parity, [2] break, [3] overrun |
| rx_break | input | 1 | Push a break-marked entry |
| rd_pop | input | 1 | Data-register read: pop the head |
| fifo_en | input | 1 | 1 selects multi-entry mode; a change flushes |
| flush | input | 1 | Empty the queue |
| stat_clr | input | 1 | Write to status register: clear rx_status |
| head_data | output | 12 | Oldest entry: flags in [11:8], character in [7:0] |
| rx_full | output | 1 | Queue holds effective-depth entries |
| rx_empty | output | 1 | Queue holds no entry |
| can_accept | output | 1 | Count below effective depth |
| rx_irq_set | output | 1 | Pulse: set receive interrupt |
| rx_irq_clr | output | 1 | Pulse: clear receive interrupt |
| rx_status | output | 4 | Flags of the last popped entry |

## Verification
The hardest cases to reach are the read position wrapping part-way through the buffer, and the cycle where a pop and a push land together while the count is 1, so that both interrupt pulses fire. The vector table reaches these by leaving the read position at a non-zero slot, draining to empty, and then issuing a combined pop-and-push step. Directed tests then fill the buffer from that offset position to all 16 entries, so that the write index wraps. They also push into a full queue and change the mode while it holds data.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int CHAR_W  = 8;
  localparam int FLAG_W  = 4;
  localparam int ENTRY_W = CHAR_W + FLAG_W;

  // Entry layout: flags above the character; framing is the lowest flag bit.
  typedef struct packed {
    logic              overrun;
    logic              brk;
    logic              parity;
    logic              framing;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  // Slot reached from a base index plus an offset, in a power-of-two ring.
  function automatic int unsigned ring_slot(int unsigned base, int unsigned off,
                                            int unsigned depth);
    return (base + off) & (depth - 1);
  endfunction

  // Effective capacity for the current mode.
  function automatic int unsigned mode_depth(logic multi, int unsigned full_depth);
    return multi ? full_depth : 1;
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  rx_entry_t        wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output rx_entry_t        rd_entry
);
  rx_entry_t slots [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        slots[s] <= wr_entry;
      end
    end
  end

  assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             fifo_en,
  input  logic             flush,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] rd_pos,
  output logic [IDX_W-1:0] wr_idx,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             mode_q,
  output logic             mode_toggle,
  output logic             full,
  output logic             empty,
  output logic             can_accept,
  output logic             irq_set,
  output logic             irq_clr
);
  logic [CNT_W-1:0] depth_now;
  logic [IDX_W-1:0] mask;
  logic             clear_ev;
  logic             take;
  logic [CNT_W-1:0] cnt_after_pop;
  logic [CNT_W-1:0] cnt_next;
  logic [IDX_W-1:0] pos_next;
  logic             set_d;
  logic             clr_d;

  assign depth_now   = CNT_W'(mode_depth(mode_q, DEPTH));
  assign mask        = IDX_W'(depth_now - CNT_W'(1));
  assign mode_toggle = fifo_en != mode_q;
  assign clear_ev    = flush | mode_toggle;
  assign can_accept  = count < depth_now;
  assign full        = count == depth_now;
  assign empty       = count == '0;

  assign pop_ok  = pop_req && !clear_ev;
  assign push_ok = push_req && can_accept && !clear_ev;
  assign take    = pop_ok && (count != '0);

  always_comb begin
    cnt_after_pop = take ? count - CNT_W'(1) : count;
    cnt_next      = cnt_after_pop + CNT_W'(push_ok);
    pos_next      = take ? ((rd_pos + IDX_W'(1)) & mask) : rd_pos;
    wr_idx        = IDX_W'(ring_slot(32'(rd_pos), 32'(count), 32'(depth_now)));
    clr_d         = pop_ok && ((cnt_after_pop + CNT_W'(1)) == CNT_W'(TRIGGER));
    set_d         = push_ok && (cnt_next == CNT_W'(TRIGGER));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rd_pos  <= '0;
      mode_q  <= 1'b0;
      irq_set <= 1'b0;
      irq_clr <= 1'b0;
    end else if (clear_ev) begin
      count   <= '0;
      rd_pos  <= '0;
      mode_q  <= fifo_en;
      irq_set <= 1'b0;
      irq_clr <= 1'b0;
    end else begin
      count   <= cnt_next;
      rd_pos  <= pos_next;
      irq_set <= set_d;
      irq_clr <= clr_d;
    end
  end
endmodule

// File: rtl/uart_rxq_stat.sv
module uart_rxq_stat
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLAG_W-1:0] load_flags,
  input  logic              clr,
  output logic [FLAG_W-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status <= '0;
    else if (load) status <= load_flags;
    else if (clr)  status <= '0;
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int RX_TRIGGER = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_data,
  input  logic [FLAG_W-1:0]  rx_err,
  input  logic               rx_break,
  input  logic               rd_pop,
  input  logic               fifo_en,
  input  logic               flush,
  input  logic               stat_clr,
  output logic [ENTRY_W-1:0] head_data,
  output logic               rx_full,
  output logic               rx_empty,
  output logic               can_accept,
  output logic               rx_irq_set,
  output logic               rx_irq_clr,
  output logic [FLAG_W-1:0]  rx_status
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] rd_pos;
  logic [IDX_W-1:0] wr_idx;
  logic             push_ok;
  logic             pop_ok;
  logic             mode_q;
  logic             mode_toggle;
  rx_entry_t        in_entry;
  rx_entry_t        head_entry;

  always_comb begin
    in_entry = {rx_err, rx_data};
    if (rx_break) begin
      in_entry      = '0;
      in_entry.brk  = 1'b1;
    end
  end

  uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIGGER(RX_TRIGGER)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_valid | rx_break), .pop_req(rd_pop),
    .fifo_en(fifo_en), .flush(flush),
    .count(count), .rd_pos(rd_pos), .wr_idx(wr_idx),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .mode_q(mode_q), .mode_toggle(mode_toggle),
    .full(rx_full), .empty(rx_empty), .can_accept(can_accept),
    .irq_set(rx_irq_set), .irq_clr(rx_irq_clr)
  );

  uart_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_idx(wr_idx), .wr_entry(in_entry),
    .rd_idx(rd_pos), .rd_entry(head_entry)
  );

  uart_rxq_stat u_stat (
    .clk(clk), .rst_n(rst_n),
    .load(pop_ok), .load_flags(head_entry[ENTRY_W-1:CHAR_W]),
    .clr(stat_clr), .status(rx_status)
  );

  assign head_data = head_entry;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             stat_clr,
  input logic             rd_pop,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             can_accept,
  input logic             rx_irq_set,
  input logic             rx_irq_clr,
  input logic [3:0]       rx_status,
  input logic             mode_q,
  input logic             mode_toggle,
  input logic [CNT_W-1:0] count
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
  p_no_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !can_accept);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (mode_q ? CNT_W'(DEPTH) : CNT_W'(1)));
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !rx_empty) |-> rx_full);
  p_set_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_set |-> !rx_empty);
  p_clr_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_clr |-> (rx_empty || rx_irq_set));
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rd_pop) |=> (rx_status == 4'd0));
  p_toggle_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_toggle |=> (rx_empty && !rx_full && !rx_irq_set));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_empty && !rx_full));
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .stat_clr(stat_clr),
  .rd_pop(rd_pop), .rx_full(rx_full), .rx_empty(rx_empty),
  .can_accept(can_accept), .rx_irq_set(rx_irq_set), .rx_irq_clr(rx_irq_clr),
  .rx_status(rx_status), .mode_q(mode_q), .mode_toggle(mode_toggle),
  .count(count)
);

// File: tb/uart_rxq_test.sv
`timescale 1ns/1ps
module uart_rxq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rd_pop = 1'b0;
  logic        fifo_en = 1'b0, flush = 1'b0, stat_clr = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [3:0]  rx_err = '0;
  logic [11:0] head_data;
  logic        rx_full, rx_empty, can_accept, rx_irq_set, rx_irq_clr;
  logic [3:0]  rx_status;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_rxq uut (.*);

  // {op[1:0], din[7:0], ein[3:0], head[11:0], empty, full, set, clr, status[3:0]}
  // op: 0 idle, 1 push, 2 pop, 3 pop and push
  localparam logic [33:0] VEC [10] = '{
    {2'd1, 8'hA5, 4'h0, 12'h0A5, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0},
    {2'd1, 8'h3C, 4'h1, 12'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0},
    {2'd1, 8'h7E, 4'h8, 12'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0},
    {2'd2, 8'h00, 4'h0, 12'h13C, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0},
    {2'd2, 8'h00, 4'h0, 12'h87E, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    {2'd2, 8'h00, 4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 4'h8},
    {2'd1, 8'h11, 4'h2, 12'h211, 1'b0, 1'b0, 1'b1, 1'b0, 4'h8},
    {2'd3, 8'h22, 4'h0, 12'h022, 1'b0, 1'b0, 1'b1, 1'b1, 4'h2},
    {2'd2, 8'h00, 4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0},
    {2'd0, 8'h00, 4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive for one edge starting at a falling edge; returns at the next falling edge.
  task automatic step(input logic [1:0] op, input logic [7:0] d, input logic [3:0] e);
    rx_valid = op[0]; rd_pop = op[1]; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rd_pop = 1'b0; rx_data = '0; rx_err = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", rx_empty, 1);
    chk("R1 full", rx_full, 0);
    chk("R1 can_accept", can_accept, 1);
    chk("R1 status", rx_status, 0);
    chk("R1 pulses", {rx_irq_set, rx_irq_clr}, 0);

    // R4 single-entry mode
    step(2'd1, 8'h41, 4'h0);
    chk("R4 full after one push", rx_full, 1);
    chk("R4 can_accept", can_accept, 0);
    chk("R5 set pulse single mode", rx_irq_set, 1);
    step(2'd1, 8'h42, 4'h0);
    chk("R4 second push dropped head", head_data, 12'h041);
    step(2'd2, 8'h00, 4'h0);
    chk("R4 empty after pop", rx_empty, 1);
    chk("R6 clr pulse", rx_irq_clr, 1);

    // R11 break entry, with rx_valid at the same time
    rx_break = 1'b1;
    step(2'd1, 8'hFF, 4'h0);
    rx_break = 1'b0;
    chk("R11 break head", head_data, 12'h400);
    step(2'd2, 8'h00, 4'h0);
    chk("R11 break status", rx_status, 4'h4);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R8 status cleared", rx_status, 0);

    // R9 switch to multi-entry mode: the change cycle ignores the push
    fifo_en = 1'b1;
    step(2'd1, 8'h99, 4'h0);
    chk("R9 toggle ignores push", rx_empty, 1);

    // Vector table (R5 R6 R7 R12)
    foreach (VEC[i]) begin
      step(VEC[i][33:32], VEC[i][31:24], VEC[i][23:20]);
      chk($sformatf("R7 vec%0d head", i), head_data, VEC[i][19:8]);
      chk($sformatf("R2 vec%0d empty/full", i), {rx_empty, rx_full}, VEC[i][7:6]);
      chk($sformatf("R5 R6 R12 vec%0d pulses", i), {rx_irq_set, rx_irq_clr}, VEC[i][5:4]);
      chk($sformatf("R7 vec%0d status", i), rx_status, VEC[i][3:0]);
    end

    // R2 fill from an offset position, R3 overflow
    for (int k = 0; k < 16; k++) begin
      step(2'd1, 8'(8'h40 + k), 4'h0);
      if (k == 14) chk("R2 not full at 15", rx_full, 0);
    end
    chk("R2 full at 16", rx_full, 1);
    chk("R3 can_accept low", can_accept, 0);
    step(2'd1, 8'hEE, 4'h3);
    for (int k = 0; k < 16; k++) begin
      chk($sformatf("R3 order slot %0d", k), head_data, 12'(8'h40 + k));
      step(2'd2, 8'h00, 4'h0);
    end
    chk("R3 dropped push absent", rx_empty, 1);

    // R8 pop load wins over same-cycle clear
    step(2'd1, 8'h99, 4'hF);
    stat_clr = 1'b1;
    step(2'd2, 8'h00, 4'h0);
    stat_clr = 1'b0;
    chk("R8 pop load wins", rx_status, 4'hF);

    // R10 flush
    step(2'd1, 8'h01, 4'h0);
    step(2'd1, 8'h02, 4'h0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R10 flush empty", {rx_empty, rx_full}, 2'b10);
    step(2'd1, 8'h55, 4'h0);
    chk("R10 new head", head_data, 12'h055);

    // R9 mode change with data held
    fifo_en = 1'b0;
    @(negedge clk);
    chk("R9 toggle empties", {rx_empty, rx_full}, 2'b10);
    step(2'd1, 8'h66, 4'h0);
    chk("R9 single mode after change", rx_full, 1);

    finish_run();
  end
endmodule